// File: doc/BRIEF.md
# Power-On Operating Mode Selector

This block settles the chip's operating mode once per power-on. Four strap inputs are captured at the release of the active-low power-on reset: a media-change strap, two port-E boot bits and a UART-reset strap. While reset is held low the strap registers follow the pins on every clock, so the value present at release is the value kept. The two active-low test pins are live inputs. They pass through a synchroniser and are decoded together with the captured straps.

The decoded mode is registered once, a fixed number of clocks after release. It then holds until the power-on reset is asserted again, so the strap and test pins can serve other functions afterwards. The block presents the mode as a 3-bit code and as a one-hot vector. It also gives the boot bus width for the normal modes, a flag that marks all test modes, an oscillator enable, and a hold signal that keeps the core logic static during the oscillator test.

In the oscillator test mode, the live port-A pins drive the six PLL control lines through a fixed per-bit inversion mask, so that an all-zero port gives the default PLL setting. In every other mode the PLL control lines carry that default. All control and status pins are plain levels. There is no streamed data and no handshake.

Top module: `strap_mode_ctrl`

## Requirements
- R1: While `por_n` is low, the strap registers load the pins on every clock. The value they hold after the first rising clock edge following the release of `por_n` is kept, and later strap changes have no effect on any output until `por_n` is asserted again.
- R2: `test_n` passes through a 2-stage synchroniser. `mode_valid` rises at the third rising clock edge after release. The mode loaded there uses the test pins as sampled at the first edge after release, and it does not change while `mode_valid` is high.
- R3: The test-pin pair `test_n[0]=1`, `test_n[1]=0` selects bypass (code 4) with `osc_en=0`. In every other mode `osc_en=1`.
- R4: The pair `test_n[0]=0`, `test_n[1]=1` with the captured UART-reset strap at 0 selects oscillator test (code 5) with `core_hold=1`. In every other mode `core_hold=0`.
- R5: `pll_ctrl` bits [5:0] are, in order, clock select, crystal enable, PLL enable, divider bit 0, divider bit 1 and PLL bypass. In oscillator test mode, `pll_ctrl = porta_in XOR 6'b111010`, following the live port-A pins. In every other mode `pll_ctrl = 6'b111010`.
- R6: With both test pins at 1 and the media strap captured at 1, the mode is normal boot. The captured port-E bits {pe[1],pe[0]} select the mode and width: 00 gives code 0 and `boot_width=2'b00` (32-bit), 01 gives code 1 and `2'b01` (8-bit), 10 gives code 2 and `2'b10` (16-bit).
- R7: In normal boot, port-E value 11 is reserved and gives code 0 with a 32-bit width.
- R8: With both test pins at 1 and the media strap captured at 0, the mode is alternative test-ROM boot (code 3) whatever the port-E bits are.
- R9: With both test pins at 0, the UART-reset strap selects in-circuit emulation (code 6) when it is 1 and the all-high-impedance system test (code 7) when it is 0.
- R10: The pair `test_n[0]=0`, `test_n[1]=1` with the UART-reset strap at 1 is reserved and decodes as system test (code 7).
- R11: `mode_onehot` has exactly the bit with the index of `mode_code` set. `test_active` is 1 for codes 3 to 7 and 0 for codes 0 to 2. `boot_width` is 2'b00 outside normal boot.
- R12: While `por_n` is low, the outputs are `mode_valid=0`, `mode_code=0`, `mode_onehot=8'h01`, `boot_width=0`, `test_active=0`, `osc_en=1`, `core_hold=0` and `pll_ctrl=6'b111010`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| test_n | input | 2 | Live active-low test-mode pins |
| media_strap | input | 1 | Media-change strap |
| porte_strap | input | 2 | Port-E boot-width straps, bit 0 = PE0 |
| ureset_strap | input | 1 | UART-reset strap |
| porta_in | input | 6 | Port-A pins, drive the PLL controls in oscillator test mode |
| mode_code | output | 3 | Encoded mode, 0..7 |
| mode_onehot | output | 8 | One-hot mode |
| mode_valid | output | 1 | Mode locked since the last reset release |
| boot_width | output | 2 | 00 32-bit, 01 8-bit, 10 16-bit |
| test_active | output | 1 | High in any non-normal mode |
| osc_en | output | 1 | Low in oscillator bypass |
| core_hold | output | 1 | High in oscillator test mode, holds the core static |
| pll_ctrl | output | 6 | PLL control lines |

## Verification
The bench changes the straps several times while reset is held. It then scrambles both the straps and the test pins after the lock point. A design that captured at the wrong edge, or that kept tracking the pins, would show a mode that differs from the value computed from the pins present at release. Directed trials cover each of the eight modes, the reserved port-E value 11 and the reserved test-pin pair with the UART-reset strap at 1; a wrong fallback would show the wrong code or width there. Port-A is varied after lock, in oscillator test mode and in the other modes, to catch a mask applied in the wrong bit order, a missing inversion, or port-A reaching the PLL controls outside the test mode.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [2:0] {
    MODE_NORM32  = 3'd0,
    MODE_NORM8   = 3'd1,
    MODE_NORM16  = 3'd2,
    MODE_ALTROM  = 3'd3,
    MODE_BYPASS  = 3'd4,
    MODE_OSCTEST = 3'd5,
    MODE_ICE     = 3'd6,
    MODE_SYSTEST = 3'd7
  } mode_e;

  localparam int NUM_MODES = 8;

  typedef enum logic [1:0] {
    BW_32 = 2'd0,
    BW_8  = 2'd1,
    BW_16 = 2'd2
  } bw_e;

  typedef struct packed {
    logic       media;
    logic [1:0] pe;
    logic       ureset;
  } strap_t;

  localparam int PLL_W = 6;
  // {clock select, crystal enable, PLL enable, div0, div1, PLL bypass}
  localparam logic [PLL_W-1:0] PLL_DEFAULT = 6'b111010;

endpackage

// File: rtl/smc_sync.sv
module smc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/smc_strap_capture.sv
module smc_strap_capture
  import smc_pkg::*;
#(
  parameter int LOCK_AT = 2
) (
  input  logic   clk,
  input  logic   por_n,
  input  strap_t pins,
  output strap_t held,
  output logic   load_mode
);
  localparam int CNT_W = $clog2(LOCK_AT + 2);
  localparam logic [CNT_W-1:0] LOCK_V = CNT_W'(LOCK_AT);
  localparam logic [CNT_W-1:0] SAT_V  = CNT_W'(LOCK_AT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cnt <= '0;
    else if (cnt != SAT_V) cnt <= cnt + 1'b1;
  end

  // transparent while cnt is zero: during reset and at the first edge after it
  always_ff @(posedge clk) begin
    if (cnt == '0) held <= pins;
  end

  assign load_mode = (cnt == LOCK_V);

  // R1: once the capture edge has passed, the held straps never move
  p_strap_frozen_r1: assert property (@(posedge clk) disable iff (!por_n)
    (cnt != '0) |=> $stable(held));

  // R2: the load pulse fires on exactly one edge per reset release
  p_single_load_r2: assert property (@(posedge clk) disable iff (!por_n)
    load_mode |=> !load_mode);
endmodule

// File: rtl/smc_decode.sv
module smc_decode
  import smc_pkg::*;
(
  input  logic [1:0] test_q,
  input  strap_t     st,
  output mode_e      mode,
  output bw_e        bw
);
  always_comb begin
    mode = MODE_SYSTEST;
    bw   = BW_32;
    case (test_q)
      2'b11: begin
        if (st.media) begin
          case (st.pe)
            2'b01:   begin mode = MODE_NORM8;  bw = BW_8;  end
            2'b10:   begin mode = MODE_NORM16; bw = BW_16; end
            default: begin mode = MODE_NORM32; bw = BW_32; end
          endcase
        end else begin
          mode = MODE_ALTROM;
        end
      end
      2'b01:   mode = MODE_BYPASS;
      2'b10:   mode = st.ureset ? MODE_SYSTEST : MODE_OSCTEST;
      default: mode = st.ureset ? MODE_ICE : MODE_SYSTEST;
    endcase
  end
endmodule

// File: rtl/smc_out.sv
module smc_out
  import smc_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             load_mode,
  input  mode_e            mode_d,
  input  bw_e              bw_d,
  input  logic [PLL_W-1:0] porta,
  output mode_e            mode_q,
  output logic [NUM_MODES-1:0] onehot,
  output logic             valid,
  output bw_e              bw_q,
  output logic             test_act,
  output logic             osc_en,
  output logic             core_hold,
  output logic [PLL_W-1:0] pll
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= MODE_NORM32;
      bw_q   <= BW_32;
      valid  <= 1'b0;
    end else if (load_mode) begin
      mode_q <= mode_d;
      bw_q   <= bw_d;
      valid  <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_onehot
    assign onehot[i] = (mode_q == mode_e'(i));
  end

  assign test_act  = (mode_q >= MODE_ALTROM);
  assign osc_en    = (mode_q != MODE_BYPASS);
  assign core_hold = (mode_q == MODE_OSCTEST);
  assign pll       = core_hold ? (porta ^ PLL_DEFAULT) : PLL_DEFAULT;

  // R2: a locked mode stays locked and unchanged
  p_mode_locked_r2: assert property (@(posedge clk) disable iff (!por_n)
    valid |=> (valid && $stable(mode_q) && $stable(bw_q)));

  // R11: exactly one one-hot bit
  p_onehot_r11: assert property (@(posedge clk) disable iff (!por_n)
    $countones(onehot) == 1);

  // R11: a non-default width only appears in a normal mode
  p_width_normal_r11: assert property (@(posedge clk) disable iff (!por_n)
    (bw_q != BW_32) |-> !test_act);

  // R3: oscillators only stop in bypass
  p_bypass_osc_r3: assert property (@(posedge clk) disable iff (!por_n)
    !osc_en |-> (onehot[MODE_BYPASS] && test_act));
endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
  import smc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic [1:0] test_n,
  input  logic       media_strap,
  input  logic [1:0] porte_strap,
  input  logic       ureset_strap,
  input  logic [5:0] porta_in,
  output logic [2:0] mode_code,
  output logic [7:0] mode_onehot,
  output logic       mode_valid,
  output logic [1:0] boot_width,
  output logic       test_active,
  output logic       osc_en,
  output logic       core_hold,
  output logic [5:0] pll_ctrl
);
  logic [1:0] test_q;
  strap_t     pins, held;
  logic       load_mode;
  mode_e      mode_d, mode_q;
  bw_e        bw_d, bw_q;

  assign pins = '{media: media_strap, pe: porte_strap, ureset: ureset_strap};

  smc_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk (clk), .d (test_n), .q (test_q)
  );

  smc_strap_capture #(.LOCK_AT(SYNC_STAGES)) u_cap (
    .clk (clk), .por_n (por_n), .pins (pins), .held (held), .load_mode (load_mode)
  );

  smc_decode u_dec (
    .test_q (test_q), .st (held), .mode (mode_d), .bw (bw_d)
  );

  smc_out u_out (
    .clk (clk), .por_n (por_n), .load_mode (load_mode),
    .mode_d (mode_d), .bw_d (bw_d), .porta (porta_in),
    .mode_q (mode_q), .onehot (mode_onehot), .valid (mode_valid),
    .bw_q (bw_q), .test_act (test_active), .osc_en (osc_en),
    .core_hold (core_hold), .pll (pll_ctrl)
  );

  assign mode_code  = mode_q;
  assign boot_width = bw_q;

  // R12: no valid mode while reset is asserted
  p_reset_invalid_r12: assert property (@(posedge clk)
    !por_n |-> !mode_valid);

  // R5: PLL lines keep their default outside the oscillator test
  p_pll_default_r5: assert property (@(posedge clk) disable iff (!por_n)
    !core_hold |-> (pll_ctrl == PLL_DEFAULT));

  // R4: core hold only with the oscillator test code
  p_hold_code_r4: assert property (@(posedge clk) disable iff (!por_n)
    core_hold |-> (mode_code == 3'd5 && osc_en));
endmodule

// File: tb/sim_strap_mode_ctrl.sv
module sim_strap_mode_ctrl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [1:0] test_n = 2'b11;
  logic       media_strap = 1'b1;
  logic [1:0] porte_strap = 2'b00;
  logic       ureset_strap = 1'b0;
  logic [5:0] porta_in = 6'd0;
  logic [2:0] mode_code;
  logic [7:0] mode_onehot;
  logic       mode_valid;
  logic [1:0] boot_width;
  logic       test_active, osc_en, core_hold;
  logic [5:0] pll_ctrl;

  int n_cmp = 0;
  int n_bad = 0;
  localparam logic [5:0] PDEF = 6'b111010;

  always #2 clk = ~clk;

  strap_mode_ctrl u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_mode(logic [1:0] t, logic m, logic [1:0] pe, logic ur);
    if (t == 2'b11) begin
      if (!m) return 3'd3;
      if (pe == 2'b01) return 3'd1;
      if (pe == 2'b10) return 3'd2;
      return 3'd0;
    end
    if (t == 2'b01) return 3'd4;
    if (t == 2'b10) return ur ? 3'd7 : 3'd5;
    return ur ? 3'd6 : 3'd7;
  endfunction

  function automatic logic [1:0] exp_bw(logic [2:0] c);
    return (c == 3'd1) ? 2'b01 : (c == 3'd2) ? 2'b10 : 2'b00;
  endfunction

  task automatic run_trial(logic [1:0] t, logic m, logic [1:0] pe, logic ur, logic [5:0] pa);
    logic [2:0] em;
    em = exp_mode(t, m, pe, ur);
    @(negedge clk);
    por_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      test_n = 2'($urandom); media_strap = 1'($urandom);
      porte_strap = 2'($urandom); ureset_strap = 1'($urandom);
      porta_in = 6'($urandom);
      @(negedge clk);
    end
    check("R12 valid low in reset", {31'd0, mode_valid}, 0);
    check("R12 reset outputs", {mode_code, mode_onehot, boot_width, test_active, osc_en, core_hold, pll_ctrl},
          {3'd0, 8'h01, 2'b00, 1'b0, 1'b1, 1'b0, PDEF});
    test_n = t; media_strap = m; porte_strap = pe; ureset_strap = ur; porta_in = pa;
    @(negedge clk);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 not valid before third edge", {31'd0, mode_valid}, 0);
    @(negedge clk);
    check("R2 valid at third edge", {31'd0, mode_valid}, 1);
    check("R6 R7 R8 R9 R10 mode code", {29'd0, mode_code}, {29'd0, em});
    check("R11 onehot", {24'd0, mode_onehot}, 32'(1) << em);
    check("R6 R11 boot width", {30'd0, boot_width}, {30'd0, exp_bw(em)});
    check("R11 test flag", {31'd0, test_active}, {31'd0, (em >= 3'd3)});
    check("R3 osc enable", {31'd0, osc_en}, {31'd0, (em != 3'd4)});
    check("R4 core hold", {31'd0, core_hold}, {31'd0, (em == 3'd5)});
    check("R5 pll ctrl", {26'd0, pll_ctrl}, {26'd0, (em == 3'd5) ? (pa ^ PDEF) : PDEF});
    test_n = ~t; media_strap = ~m; porte_strap = ~pe; ureset_strap = ~ur;
    porta_in = 6'($urandom);
    repeat (4) @(negedge clk);
    check("R1 R2 mode held after pin change", {29'd0, mode_code, boot_width}, {29'd0, em, exp_bw(em)});
    check("R5 pll follows live port A", {26'd0, pll_ctrl}, {26'd0, (em == 3'd5) ? (porta_in ^ PDEF) : PDEF});
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // directed: every mode and the reserved codes
    run_trial(2'b11, 1'b1, 2'b00, 1'b0, 6'd0);  // R6 32-bit
    run_trial(2'b11, 1'b1, 2'b01, 1'b1, 6'd0);  // R6 8-bit
    run_trial(2'b11, 1'b1, 2'b10, 1'b0, 6'd0);  // R6 16-bit
    run_trial(2'b11, 1'b1, 2'b11, 1'b0, 6'd0);  // R7 reserved width
    run_trial(2'b11, 1'b0, 2'b01, 1'b0, 6'd0);  // R8 alt ROM
    run_trial(2'b01, 1'b0, 2'b00, 1'b1, 6'd0);  // R3 bypass
    run_trial(2'b10, 1'b1, 2'b00, 1'b0, 6'd0);  // R4 R5 osc test, all-zero port
    run_trial(2'b10, 1'b1, 2'b00, 1'b0, 6'b100001); // R5 inversion order
    run_trial(2'b10, 1'b1, 2'b00, 1'b1, 6'd0);  // R10 reserved pair
    run_trial(2'b00, 1'b1, 2'b00, 1'b1, 6'd0);  // R9 ICE
    run_trial(2'b00, 1'b1, 2'b00, 1'b0, 6'd0);  // R9 system test
    for (int i = 0; i < 200; i++)
      run_trial(2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 6'($urandom));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule